// File: doc/BRIEF.md
# Timer Interrupt Flag and Enable Unit

This unit keeps the interrupt status flags and the interrupt enables for a 16-bit timer/counter. The timer has three output-compare channels, one input-capture channel and an overflow event. The timer core is not part of this block. It appears only as single-cycle event pulses, a qualified timer tick and the 4-bit waveform mode. The unit records each event in a sticky flag. The waveform mode decides which core event sets the overflow flag and which sets the capture flag. A compare hit reaches its flag one qualified timer tick late. A match that comes together with a forced-compare strobe is dropped.

Software reaches the unit through a small 8-bit register port: a 2-bit address, a write strobe, write data and combinational read data. A flag is cleared in one of two ways: software writes a one to its bit, or the interrupt controller pulses the acknowledge line of that source when it takes the vector. Each source drives its own request line. The line is high while the flag is set, its enable bit is one and the global interrupt-enable input is high. Vector priority is left to the interrupt controller.

Top module: `tmr_irq_unit`

## Requirements
- R1: Address 0 reads the flag register, laid out as: bit 0 overflow, bit 1 compare A, bit 2 compare B, bit 3 compare C, bit 5 input capture. Bits 4, 6 and 7 always read 0. Address 1 reads the enable register, which uses the same layout. Addresses 2 and 3 read 0.
- R2: After reset, both registers and every request line are zero.
- R3: A write to address 0 clears each flag whose data bit is one. Flags whose data bit is zero keep their value.
- R4: A one on `src_ack[i]` clears the flag of source i for that clock. The source index order for `src_ack` and `irq_req` is: 0 overflow, 1 compare A, 2 compare B, 3 compare C, 4 input capture.
- R5: A compare hit is sampled on a cycle with `tmr_tick` high. Its flag sets on the next cycle with `tmr_tick` high, counting qualified ticks and not bus clocks.
- R6: A compare hit sampled in the same tick as that channel's `frc_strobe` bit does not set the flag.
- R7: In waveform modes 8, 10, 12 and 14, the capture flag is set by `ev_top` and `ev_capture` is ignored. In all other modes it is set by `ev_capture`.
- R8: The overflow flag is set by `ev_wrap` in modes 0, 4, 12 and 13. It is set by `ev_top` in modes 5, 6, 7, 14 and 15. It is set by `ev_bottom` in modes 1, 2, 3, 8, 9, 10 and 11.
- R9: `irq_req[i]` is high exactly when flag i is set, its enable bit is one and `gie` is high.
- R10: When a set event and a clear (write-one or acknowledge) hit the same flag in the same cycle, the flag ends set.
- R11: Writes to reserved bit positions have no effect. The enable register keeps zeros there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 2 | Register address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| gie | input | 1 | Global interrupt enable |
| tmr_tick | input | 1 | Timer clock qualifier |
| wgm_mode | input | 4 | Waveform generation mode |
| ev_wrap | input | 1 | Counter wrapped past its maximum |
| ev_top | input | 1 | Counter reached TOP |
| ev_bottom | input | 1 | Counter reached BOTTOM |
| ev_match | input | 3 | Compare hit for channels A, B, C |
| frc_strobe | input | 3 | Forced-compare strobes for channels A, B, C |
| ev_capture | input | 1 | Input capture event |
| src_ack | input | 5 | Per-source vector acknowledge |
| irq_req | output | 5 | Per-source interrupt request |

## Verification
The bench holds a compare hit pending through several bus clocks with the tick low. A design that counted bus clocks instead of ticks would show the compare flag too early. It raises a hit together with a forced-compare strobe, which a design that ignored the strobe would record. Capture and overflow events are driven under several waveform modes, including one where both flags come from the same TOP event. A wrong mode decode would set the wrong flag or miss one. Set events are driven in the same cycle as write-one and acknowledge clears. A design that let the clear win would lose the event.

// File: rtl/tmr_irq_pkg.sv
package tmr_irq_pkg;

  localparam int NCMP     = 3;
  localparam int NSRC     = NCMP + 2;
  localparam int DW       = 8;
  localparam int AW       = 2;
  localparam int SRC_OVF  = 0;
  localparam int SRC_CAPT = NCMP + 1;

  localparam logic [AW-1:0] ADDR_FLAGS  = 2'd0;
  localparam logic [AW-1:0] ADDR_ENABLE = 2'd1;

  typedef enum logic [1:0] {
    OVF_ON_WRAP   = 2'd0,
    OVF_ON_TOP    = 2'd1,
    OVF_ON_BOTTOM = 2'd2
  } ovf_sel_e;

  // Register bit that carries source s (capture sits above a reserved bit).
  function automatic int src_bit(input int s);
    return (s == SRC_CAPT) ? SRC_CAPT + 1 : s;
  endfunction

  // Which counter event the overflow flag follows in a waveform mode.
  function automatic ovf_sel_e ovf_select(input logic [3:0] mode);
    case (mode)
      4'd1, 4'd2, 4'd3, 4'd8,
      4'd9, 4'd10, 4'd11:        return OVF_ON_BOTTOM;
      4'd5, 4'd6, 4'd7,
      4'd14, 4'd15:              return OVF_ON_TOP;
      default:                   return OVF_ON_WRAP;
    endcase
  endfunction

  // Modes where the capture register serves as TOP.
  function automatic logic capt_is_top(input logic [3:0] mode);
    return (mode == 4'd8) || (mode == 4'd10) || (mode == 4'd12) || (mode == 4'd14);
  endfunction

  // Mask of writable bits in the register layout.
  function automatic logic [DW-1:0] live_mask();
    logic [DW-1:0] m;
    m = '0;
    for (int s = 0; s < NSRC; s++) m[src_bit(s)] = 1'b1;
    return m;
  endfunction

endpackage

// File: rtl/tmr_irq_evt.sv
module tmr_irq_evt
  import tmr_irq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tmr_tick,
  input  logic [3:0]      wgm_mode,
  input  logic            ev_wrap,
  input  logic            ev_top,
  input  logic            ev_bottom,
  input  logic [NCMP-1:0] ev_match,
  input  logic [NCMP-1:0] frc_strobe,
  input  logic            ev_capture,
  output logic [NSRC-1:0] set_evt
);

  logic [NCMP-1:0] cmp_pend;
  logic [NCMP-1:0] cmp_set;
  logic            ovf_set;
  logic            capt_set;

  // Compare hits wait one qualified tick before reaching their flag.
  always_ff @(posedge clk) begin
    if (!rst_n)        cmp_pend <= '0;
    else if (tmr_tick) cmp_pend <= ev_match & ~frc_strobe;
  end

  assign cmp_set = cmp_pend & {NCMP{tmr_tick}};

  always_comb begin
    unique case (ovf_select(wgm_mode))
      OVF_ON_TOP:    ovf_set = ev_top;
      OVF_ON_BOTTOM: ovf_set = ev_bottom;
      default:       ovf_set = ev_wrap;
    endcase
  end

  assign capt_set = capt_is_top(wgm_mode) ? ev_top : ev_capture;

  assign set_evt = {capt_set, cmp_set, ovf_set};

  generate
    for (genvar c = 0; c < NCMP; c++) begin : g_cmp_chk
      // R5: a sampled unforced hit is held pending for the next tick
      a_r5_hit_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_tick && ev_match[c] && !frc_strobe[c]) |=> cmp_pend[c]);
      // R6: a forced strobe leaves nothing pending
      a_r6_force_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_tick && frc_strobe[c]) |=> !cmp_pend[c]);
      // R5: no pending state changes between ticks
      a_r5_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
        !tmr_tick |=> $stable(cmp_pend[c]));
    end
  endgenerate

endmodule

// File: rtl/tmr_irq_flags.sv
module tmr_irq_flags
  import tmr_irq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] set_evt,
  input  logic [NSRC-1:0] clr_req,
  output logic [NSRC-1:0] flags
);

  generate
    for (genvar s = 0; s < NSRC; s++) begin : g_flag
      always_ff @(posedge clk) begin
        if (!rst_n)          flags[s] <= 1'b0;
        else if (set_evt[s]) flags[s] <= 1'b1;
        else if (clr_req[s]) flags[s] <= 1'b0;
      end

      // R10: a set event is never lost to a same-cycle clear
      a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set_evt[s] |=> flags[s]);
      // R3/R4: a clear without a set empties the flag
      a_r3_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req[s] && !set_evt[s]) |=> !flags[s]);
      // R3: without any event the flag holds
      a_r3_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_req[s] && !set_evt[s]) |=> $stable(flags[s]));
    end
  endgenerate

endmodule

// File: rtl/tmr_irq_regs.sv
module tmr_irq_regs
  import tmr_irq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   bus_addr,
  input  logic            bus_we,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  input  logic [NSRC-1:0] flags,
  input  logic [NSRC-1:0] src_ack,
  output logic [NSRC-1:0] enables,
  output logic [NSRC-1:0] clr_req
);

  logic [NSRC-1:0] wdata_src;
  logic [DW-1:0]   flag_view;
  logic [DW-1:0]   en_view;
  logic            wr_flags;
  logic            wr_enable;
  logic            wdata_unused;

  assign wr_flags  = bus_we && (bus_addr == ADDR_FLAGS);
  assign wr_enable = bus_we && (bus_addr == ADDR_ENABLE);

  always_comb begin
    flag_view = '0;
    en_view   = '0;
    for (int s = 0; s < NSRC; s++) begin
      wdata_src[s]          = bus_wdata[src_bit(s)];
      flag_view[src_bit(s)] = flags[s];
      en_view[src_bit(s)]   = enables[s];
    end
  end

  assign wdata_unused = ^(bus_wdata & ~live_mask());

  always_ff @(posedge clk) begin
    if (!rst_n)         enables <= '0;
    else if (wr_enable) enables <= wdata_src;
  end

  assign clr_req = src_ack | (wdata_src & {NSRC{wr_flags}});

  always_comb begin
    unique case (bus_addr)
      ADDR_FLAGS:  bus_rdata = flag_view;
      ADDR_ENABLE: bus_rdata = en_view;
      default:     bus_rdata = '0;
    endcase
  end

  // R11: an enable write loads exactly the live bits
  a_r11_enable_load: assert property (@(posedge clk) disable iff (!rst_n)
    wr_enable |=> (enables == $past(wdata_src)));

endmodule

// File: rtl/tmr_irq_unit.sv
module tmr_irq_unit
  import tmr_irq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  bus_addr,
  input  logic        bus_we,
  input  logic [7:0]  bus_wdata,
  output logic [7:0]  bus_rdata,
  input  logic        gie,
  input  logic        tmr_tick,
  input  logic [3:0]  wgm_mode,
  input  logic        ev_wrap,
  input  logic        ev_top,
  input  logic        ev_bottom,
  input  logic [2:0]  ev_match,
  input  logic [2:0]  frc_strobe,
  input  logic        ev_capture,
  input  logic [4:0]  src_ack,
  output logic [4:0]  irq_req
);

  logic [NSRC-1:0] set_evt;
  logic [NSRC-1:0] clr_req;
  logic [NSRC-1:0] flags;
  logic [NSRC-1:0] enables;

  tmr_irq_evt i_evt (
    .clk        (clk),
    .rst_n      (rst_n),
    .tmr_tick   (tmr_tick),
    .wgm_mode   (wgm_mode),
    .ev_wrap    (ev_wrap),
    .ev_top     (ev_top),
    .ev_bottom  (ev_bottom),
    .ev_match   (ev_match),
    .frc_strobe (frc_strobe),
    .ev_capture (ev_capture),
    .set_evt    (set_evt)
  );

  tmr_irq_flags i_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_evt (set_evt),
    .clr_req (clr_req),
    .flags   (flags)
  );

  tmr_irq_regs i_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .flags     (flags),
    .src_ack   (src_ack),
    .enables   (enables),
    .clr_req   (clr_req)
  );

  assign irq_req = flags & enables & {NSRC{gie}};

  // R7: in capture-as-TOP modes a capture pulse alone never sets the flag
  a_r7_capture_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (capt_is_top(wgm_mode) && ev_capture && !ev_top && !flags[SRC_CAPT])
      |=> !flags[SRC_CAPT]);
  // R9: a request needs the global enable
  a_r9_gie_gates: assert property (@(posedge clk) disable iff (!rst_n)
    !gie |-> (irq_req == '0));
  // R1: reserved bits of the flag view read zero
  a_r1_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rdata & ~live_mask()) == '0);

endmodule

// File: tb/test_tmr_irq_unit.sv
module test_tmr_irq_unit;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] bus_addr;
  logic       bus_we;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic       gie;
  logic       tmr_tick;
  logic [3:0] wgm_mode;
  logic       ev_wrap, ev_top, ev_bottom, ev_capture;
  logic [2:0] ev_match, frc_strobe;
  logic [4:0] src_ack;
  logic [4:0] irq_req;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  tmr_irq_unit i_tmr_irq_unit (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .gie(gie),
    .tmr_tick(tmr_tick), .wgm_mode(wgm_mode), .ev_wrap(ev_wrap),
    .ev_top(ev_top), .ev_bottom(ev_bottom), .ev_match(ev_match),
    .frc_strobe(frc_strobe), .ev_capture(ev_capture),
    .src_ack(src_ack), .irq_req(irq_req)
  );

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic idle_inputs();
    bus_we = 0; bus_addr = 0; bus_wdata = 0;
    ev_wrap = 0; ev_top = 0; ev_bottom = 0; ev_capture = 0;
    ev_match = 0; frc_strobe = 0; src_ack = 0;
  endtask

  task automatic step();
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    bus_we = 1; bus_addr = a; bus_wdata = d;
    step();
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic clear_all();
    wr(2'd0, 8'hFF);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rd(2'd0, v); check("R2 flags after reset", v, 8'h00);
    rd(2'd1, v); check("R2 enables after reset", v, 8'h00);
    check("R2 irq after reset", {3'b0, irq_req}, 8'h00);
  endtask

  task automatic t_layout();
    logic [7:0] v;
    wr(2'd1, 8'hFF);
    rd(2'd1, v); check("R11 enable reserved bits stay zero", v, 8'h2F);
    rd(2'd2, v); check("R1 address 2 reads zero", v, 8'h00);
    rd(2'd3, v); check("R1 address 3 reads zero", v, 8'h00);
    wgm_mode = 4'd0;
    ev_wrap = 1; ev_capture = 1; step();
    rd(2'd0, v); check("R1 overflow bit0 capture bit5", v, 8'h21);
    wr(2'd0, 8'hD0);
    rd(2'd0, v); check("R11 reserved write leaves flags", v, 8'h21);
    wr(2'd1, 8'h00);
  endtask

  task automatic t_clear();
    logic [7:0] v;
    wgm_mode = 4'd0;
    ev_wrap = 1; ev_capture = 1; step();
    wr(2'd0, 8'h00);
    rd(2'd0, v); check("R3 zero write keeps flags", v, 8'h21);
    wr(2'd0, 8'h01);
    rd(2'd0, v); check("R3 write one clears only bit0", v, 8'h20);
    src_ack = 5'b10000; step();
    rd(2'd0, v); check("R4 capture ack clears", v, 8'h00);
  endtask

  task automatic t_compare_delay();
    logic [7:0] v;
    tmr_tick = 1; ev_match = 3'b001; step();
    tmr_tick = 0;
    rd(2'd0, v); check("R5 no flag in match tick", v, 8'h00);
    for (int i = 0; i < 3; i++) step();
    rd(2'd0, v); check("R5 no flag without a tick", v, 8'h00);
    tmr_tick = 1; step();
    rd(2'd0, v); check("R5 flag after next tick", v, 8'h02);
    clear_all();
  endtask

  task automatic t_force();
    logic [7:0] v;
    tmr_tick = 1;
    ev_match = 3'b110; frc_strobe = 3'b010; step();
    step();
    rd(2'd0, v); check("R6 forced B masked, C set", v, 8'h08);
    clear_all();
  endtask

  task automatic t_capture_modes();
    logic [7:0] v;
    wgm_mode = 4'd12;
    ev_capture = 1; step();
    rd(2'd0, v); check("R7 capture ignored in mode 12", v, 8'h00);
    ev_top = 1; step();
    rd(2'd0, v); check("R7 top sets capture in mode 12", v, 8'h20);
    clear_all();
    wgm_mode = 4'd14;
    ev_top = 1; step();
    rd(2'd0, v); check("R7 R8 mode 14 top sets both", v, 8'h21);
    clear_all();
  endtask

  task automatic t_overflow_modes();
    logic [7:0] v;
    wgm_mode = 4'd1;
    ev_wrap = 1; ev_top = 1; step();
    rd(2'd0, v); check("R8 mode 1 ignores wrap/top", v, 8'h00);
    ev_bottom = 1; step();
    rd(2'd0, v); check("R8 mode 1 bottom sets overflow", v, 8'h01);
    clear_all();
    wgm_mode = 4'd6;
    ev_bottom = 1; ev_wrap = 1; step();
    rd(2'd0, v); check("R8 mode 6 ignores bottom/wrap", v, 8'h00);
    ev_top = 1; step();
    rd(2'd0, v); check("R8 mode 6 top sets overflow", v, 8'h01);
    clear_all();
    wgm_mode = 4'd4;
    ev_top = 1; ev_bottom = 1; step();
    rd(2'd0, v); check("R8 mode 4 ignores top/bottom", v, 8'h00);
    ev_wrap = 1; step();
    rd(2'd0, v); check("R8 mode 4 wrap sets overflow", v, 8'h01);
    clear_all();
    wgm_mode = 4'd0;
  endtask

  task automatic t_set_wins();
    logic [7:0] v;
    ev_wrap = 1; step();
    ev_wrap = 1; bus_we = 1; bus_addr = 2'd0; bus_wdata = 8'h01; step();
    rd(2'd0, v); check("R10 set beats write-one", v, 8'h01);
    ev_wrap = 1; src_ack = 5'b00001; step();
    rd(2'd0, v); check("R10 set beats acknowledge", v, 8'h01);
    clear_all();
  endtask

  task automatic t_irq();
    logic [7:0] v;
    wgm_mode = 4'd0;
    ev_wrap = 1; ev_capture = 1; step();
    gie = 1;
    #1 check("R9 no enable no request", {3'b0, irq_req}, 8'h00);
    wr(2'd1, 8'h20);
    #1 check("R9 capture request", {3'b0, irq_req}, 8'h10);
    gie = 0;
    #1 check("R9 gie low blocks", {3'b0, irq_req}, 8'h00);
    gie = 1;
    wr(2'd1, 8'h21);
    #1 check("R9 overflow and capture request", {3'b0, irq_req}, 8'h11);
    src_ack = 5'b00001; step();
    #1 check("R4 R9 ack drops overflow request", {3'b0, irq_req}, 8'h10);
    rd(2'd0, v); check("R4 ack left capture flag", v, 8'h20);
  endtask

  initial begin
    idle_inputs();
    rst_n = 0; gie = 0; tmr_tick = 0; wgm_mode = 4'd0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_layout();
    t_clear();
    t_compare_delay();
    t_force();
    t_capture_modes();
    t_overflow_modes();
    t_set_wins();
    t_irq();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

endmodule